// File: doc/BRIEF.md
# Streaming SPI Master

This block is a full-duplex SPI master controlled through a small 32-bit register port. Software queues data elements into a transmit FIFO, picks a slave through a one-hot select register and sets the enable bit. From then on the master shifts one element after another with no idle time between them, as long as the transmit FIFO holds data. Every element shifted out on `mosi` is matched by one element shifted in from `miso` and stored in a receive FIFO, which software drains through the same data register.

The slave-select lines can be handled in two ways. In automatic mode the block drives the selected line low for the whole burst: half a serial-clock period before the first element and half a period after the last one. In manual mode the select lines follow the select register directly, whatever the engine is doing. The serial clock is the system clock divided by an even ratio. Clock polarity and phase come from two control bits, and these take a new value only while the engine is idle.

Register map (word offsets, whole-word access only): 0x0 control (bit0 enable, bit1 clock polarity, bit2 clock phase, bit3 manual select); 0x4 status (bit0 tx empty, bit1 tx full, bit2 rx empty, bit3 rx full, bit4 sticky tx overflow, bit5 busy; writing 1 to bit4 clears it); 0x8 slave select (bit i set selects line i); 0xC data (a write queues a tx element, a read returns and removes the oldest rx element).

Top module: `spi_stream_master`

## Requirements
- R1: After reset, all `ss_n` lines are high, `sclk` is 0 and the status register reads 0x05 (tx empty and rx empty set, every other bit clear).
- R2: Each element goes out on `mosi` MSB first. Each element received from `miso` is stored in the rx FIFO, and reads of register 0xC return the stored elements in arrival order.
- R3: With K elements queued before enabling in automatic mode, the selected line goes low exactly once and stays low for (2·XFER_W·K + 2)·CLK_DIV/2 clock cycles, so there is no gap between elements.
- R4: `sclk` rests at the polarity bit. With phase 0 the data is sampled on the leading edge; with phase 1 it is sampled on the trailing edge. This holds in all four modes.
- R5: A control write during a burst leaves the polarity and phase bits unchanged, while the enable and manual bits still update.
- R6: In automatic mode only the selected line goes low and only during a burst. In manual mode `ss_n` equals the inverted select register at all times, including during transfers.
- R7: Status bits 0–3 report tx empty, tx full, rx empty and rx full. Bit 5 reports that a burst is in progress.
- R8: A data write while 16 elements are queued is dropped and sets status bit 4. The bit stays set until a status write with bit 4 = 1 clears it.
- R9: An access whose byte enables are not all ones (4'hF) has no effect: it neither queues data nor pops data nor changes any register.
- R10: An element received while the rx FIFO holds 16 elements is discarded, and the 16 stored elements are kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops rx at 0xC) |
| reg_addr | input | 4 | Byte address of the register |
| reg_be | input | 4 | Byte enables; only 4'hF is accepted |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | N_SS | Active-low slave selects |

## Verification
The bench looks at the joints between elements. It counts the cycles each select line stays low and the number of falling edges it makes; a master that paused or raised its select line between elements would give a longer or split low interval. A monitor samples `mosi` on the edge that the current mode defines, in all four modes, so a design with the edges swapped or the bit order reversed would deliver corrupted words. The bench also fills both FIFOs to the limit: a design that overwrote the oldest entry, or let the 17th element through, would return the wrong sequence or a cleared flag. It tries a polarity change during a burst and narrow byte-enable writes, and a design that honoured either would show a changed readback or a non-empty FIFO.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} spim_st_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_SSEL = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    localparam int B_EN     = 0;
    localparam int B_CPOL   = 1;
    localparam int B_CPHA   = 2;
    localparam int B_MANUAL = 3;

    localparam int S_TXE  = 0;
    localparam int S_TXF  = 1;
    localparam int S_RXE  = 2;
    localparam int S_RXF  = 3;
    localparam int S_OVF  = 4;
    localparam int S_BUSY = 5;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        empty   = (f_q.cnt == '0);
        full    = (f_q.cnt == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            f_d.mem[f_q.wp] = wdata;
            f_d.wp = (f_q.wp == PW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == PW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
        rdata = f_q.mem[f_q.rp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // R8 / R10: a push into a full FIFO leaves the fill level alone
    p_full_push_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (f_q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_data,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_data,
    output logic         busy,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int HB   = $clog2(2 * W);

    typedef struct packed {
        spim_st_e      st;
        logic [CW-1:0] cnt;
        logic [HB-1:0] half;
        logic [W-1:0]  sh;
        logic          samp;
    } eng_t;

    eng_t e_d, e_q;
    logic tick;

    always_comb begin
        e_d     = e_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_data = {e_q.sh[W-2:0], e_q.samp};
        tick    = (e_q.cnt == CW'(HALF - 1));
        if (e_q.st != ST_IDLE) e_d.cnt = tick ? '0 : e_q.cnt + 1'b1;
        else                   e_d.cnt = '0;
        case (e_q.st)
            ST_IDLE: if (en && tx_valid) begin
                e_d.st = ST_LEAD;
                e_d.sh = tx_data;
                tx_pop = 1'b1;
            end
            ST_LEAD: if (tick) begin
                e_d.st   = ST_SHIFT;
                e_d.half = '0;
            end
            ST_SHIFT: if (tick) begin
                if (!e_q.half[0]) begin
                    e_d.samp = miso;
                    e_d.half = e_q.half + 1'b1;
                end else if (e_q.half == HB'(2 * W - 1)) begin
                    rx_push = 1'b1;
                    if (en && tx_valid) begin
                        e_d.sh   = tx_data;
                        e_d.half = '0;
                        tx_pop   = 1'b1;
                    end else begin
                        e_d.st = ST_TRAIL;
                    end
                end else begin
                    e_d.sh   = {e_q.sh[W-2:0], e_q.samp};
                    e_d.half = e_q.half + 1'b1;
                end
            end
            default: if (tick) e_d.st = ST_IDLE;
        endcase
        busy = (e_q.st != ST_IDLE);
        sclk = (e_q.st == ST_SHIFT) ? (cpol ^ cpha ^ e_q.half[0]) : cpol;
        mosi = e_q.sh[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    // R4: sclk only moves at a half-period boundary once a burst runs
    p_sclk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st != ST_IDLE && !tick) |=> $stable(sclk));
    // R3: the engine only takes an element that exists
    p_pop_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_valid && en));
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
    import spim_pkg::*;
#(
    parameter int XFER_W   = 8,
    parameter int N_SS     = 4,
    parameter int CLK_DIV  = 4,
    parameter bit HAS_FIFO = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [N_SS-1:0]   ss_n
);
    localparam int DEPTH = HAS_FIFO ? 16 : 1;

    typedef struct packed {
        logic            en;
        logic            cpol;
        logic            cpha;
        logic            manual;
        logic            ovf;
        logic [N_SS-1:0] ssel;
    } regs_t;

    regs_t r_d, r_q;
    logic acc_ok;
    logic [1:0] widx;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic tx_empty, tx_full, rx_empty, rx_full, busy;
    logic [XFER_W-1:0] tx_head, rx_word, rx_head;

    always_comb begin
        r_d     = r_q;
        tx_push = 1'b0;
        rx_pop  = 1'b0;
        acc_ok  = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
        widx    = reg_addr[3:2];
        if (reg_wr && acc_ok) begin
            case (widx)
                A_CTRL: begin
                    r_d.en     = reg_wdata[B_EN];
                    r_d.manual = reg_wdata[B_MANUAL];
                    if (!busy) begin
                        r_d.cpol = reg_wdata[B_CPOL];
                        r_d.cpha = reg_wdata[B_CPHA];
                    end
                end
                A_STAT:  if (reg_wdata[S_OVF]) r_d.ovf = 1'b0;
                A_SSEL:  r_d.ssel = reg_wdata[N_SS-1:0];
                default: if (tx_full) r_d.ovf = 1'b1;
                         else         tx_push = 1'b1;
            endcase
        end
        if (reg_rd && acc_ok && widx == A_DATA && !rx_empty) rx_pop = 1'b1;
        reg_rdata = '0;
        case (widx)
            A_CTRL: begin
                reg_rdata[B_EN]     = r_q.en;
                reg_rdata[B_CPOL]   = r_q.cpol;
                reg_rdata[B_CPHA]   = r_q.cpha;
                reg_rdata[B_MANUAL] = r_q.manual;
            end
            A_STAT: begin
                reg_rdata[S_TXE]  = tx_empty;
                reg_rdata[S_TXF]  = tx_full;
                reg_rdata[S_RXE]  = rx_empty;
                reg_rdata[S_RXF]  = rx_full;
                reg_rdata[S_OVF]  = r_q.ovf;
                reg_rdata[S_BUSY] = busy;
            end
            A_SSEL:  reg_rdata[N_SS-1:0] = r_q.ssel;
            default: reg_rdata[XFER_W-1:0] = rx_head;
        endcase
        ss_n = (r_q.manual || busy) ? ~r_q.ssel : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    spim_fifo #(.W(XFER_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(reg_wdata[XFER_W-1:0]),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

    spim_fifo #(.W(XFER_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

    spim_engine #(.W(XFER_W), .DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(r_q.en), .cpol(r_q.cpol), .cpha(r_q.cpha),
        .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_word), .busy(busy),
        .sclk(sclk), .mosi(mosi), .miso(miso));

    // R5: clock mode frozen while the engine runs
    p_mode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({r_q.cpol, r_q.cpha}));
    // R8: overflow flag holds until explicitly cleared
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf && !(reg_wr && acc_ok && widx == A_STAT && reg_wdata[S_OVF])) |=> r_q.ovf);
    // R9: a narrow write never reaches the tx FIFO
    p_narrow_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_be != 4'hF) |-> !tx_push);
endmodule

// File: tb/spi_stream_master_tb.sv
module spi_stream_master_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'h0, reg_be = 4'hF;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic sclk, mosi, miso;
    logic [3:0] ss_n;

    int ntests = 0, nfail = 0;
    logic cpol_tb = 1'b0, cpha_tb = 1'b0;
    logic [7:0] mon_words [64];
    int mon_cnt = 0, nb = 0;
    logic [7:0] bits = '0;
    logic sclk_prev = 1'b0;
    int lowcnt = 0, falls = 0, bad_ss = 0;
    logic [3:0] ss_ok = 4'hF;
    logic [3:0] ss_prev = 4'hF;

    always #10 clk = ~clk;
    assign miso = ~mosi;

    spi_stream_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

    // serial monitor: sample mosi on the mode's sampling edge
    always @(sclk or ss_n) begin
        if (&ss_n) nb = 0;
        else if (sclk !== sclk_prev && ((sclk != cpol_tb) ^ cpha_tb)) begin
            bits = {bits[6:0], mosi};
            nb++;
            if (nb == 8) begin
                if (mon_cnt < 64) mon_words[mon_cnt] = bits;
                mon_cnt++;
                nb = 0;
            end
        end
        sclk_prev = sclk;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (ss_n != 4'hF) lowcnt++;
            if (ss_prev == 4'hF && ss_n != 4'hF) falls++;
            if (ss_n != 4'hF && ss_n != ss_ok) bad_ss++;
        end
        ss_prev = ss_n;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'hF;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_be = 4'hF;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            rd(4'h4, s);
            if (!s[5]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] s;
        check(ss_n == 4'hF, "R1 ss_n", ss_n, 4'hF);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        rd(4'h4, s);
        check(s == 32'h5, "R1 status", s, 32'h5);
    endtask

    task automatic t_narrow();
        logic [31:0] s;
        wr(4'hC, 32'h5A, 4'h3);
        wr(4'h0, 32'h7, 4'h1);
        rd(4'h4, s);
        check(s[0] == 1'b1, "R9 narrow data write ignored", s, 32'h5);
        rd(4'h0, s);
        check(s == 32'h0, "R9 narrow ctrl write ignored", s, 0);
    endtask

    task automatic t_burst(input logic pol, input logic pha, input int k);
        logic [31:0] s;
        logic [7:0] tx [4];
        int l0, f0, m0;
        wr(4'h0, {29'd0, pha, pol, 1'b0});
        cpol_tb = pol; cpha_tb = pha;
        @(negedge clk);
        check(sclk == pol, "R4 idle level", sclk, pol);
        wr(4'h8, 32'h4); ss_ok = 4'b1011;
        for (int i = 0; i < k; i++) begin
            tx[i] = 8'h93 + 8'(i * 37) + {pol, pha, 6'd0};
            wr(4'hC, {24'd0, tx[i]});
        end
        l0 = lowcnt; f0 = falls; m0 = mon_cnt;
        wr(4'h0, {29'd0, pha, pol, 1'b1});
        if (k == 4) begin
            repeat (8) @(negedge clk);
            wr(4'h0, {29'd0, ~pha, ~pol, 1'b1});
            rd(4'h0, s);
            check(s[2:0] == {pha, pol, 1'b1}, "R5 mode frozen while busy", s[2:0], {pha, pol, 1'b1});
        end
        wait_idle();
        wr(4'h0, {29'd0, pha, pol, 1'b0});
        check(falls - f0 == 1, "R3 single select interval", falls - f0, 1);
        check(lowcnt - l0 == (16 * k + 2) * 2, "R3 burst length", lowcnt - l0, (16 * k + 2) * 2);
        check(mon_cnt - m0 == k, "R4 element count", mon_cnt - m0, k);
        for (int i = 0; i < k; i++) begin
            check(mon_words[m0 + i] == tx[i], "R2 R4 mosi word", mon_words[m0 + i], tx[i]);
            rd(4'hC, s);
            check(s[7:0] == ~tx[i], "R2 rx word", s[7:0], ~tx[i]);
        end
        check(sclk == pol, "R4 idle level after", sclk, pol);
        check(bad_ss == 0, "R6 only selected line low", bad_ss, 0);
    endtask

    task automatic t_fill();
        logic [31:0] s;
        int m0;
        cpol_tb = 0; cpha_tb = 0;
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h1); ss_ok = 4'b1110;
        for (int i = 0; i < 16; i++) wr(4'hC, 32'(8'h10 + i));
        rd(4'h4, s);
        check(s[1:0] == 2'b10, "R7 tx full/not empty", s[1:0], 2'b10);
        wr(4'hC, 32'hEE);
        rd(4'h4, s);
        check(s[4] == 1'b1, "R8 overflow set", s[4], 1);
        wr(4'h4, 32'h0);
        rd(4'h4, s);
        check(s[4] == 1'b1, "R8 overflow sticky", s[4], 1);
        wr(4'h4, 32'h10);
        rd(4'h4, s);
        check(s[4] == 1'b0, "R8 overflow cleared", s[4], 0);
        m0 = mon_cnt;
        wr(4'h0, 32'h1);
        repeat (10) @(negedge clk);
        rd(4'h4, s);
        check(s[5] == 1'b1, "R7 busy during burst", s[5], 1);
        wait_idle();
        rd(4'h4, s);
        check(s[3:0] == 4'b1001, "R7 rx full tx empty", s[3:0], 4'b1001);
        wr(4'hC, 32'h3C);
        wait_idle();
        wr(4'h0, 32'h0);
        check(mon_cnt - m0 == 17, "R8 dropped word not sent", mon_cnt - m0, 17);
        check(mon_words[m0 + 16] == 8'h3C, "R10 extra element sent", mon_words[m0 + 16], 8'h3C);
        rd(4'hC, s, 4'h7);
        rd(4'h4, s);
        check(s[3] == 1'b1, "R9 narrow read does not pop", s[3], 1);
        for (int i = 0; i < 16; i++) begin
            rd(4'hC, s);
            check(s[7:0] == ~(8'h10 + 8'(i)), "R10 rx kept oldest", s[7:0], ~(8'h10 + 8'(i)));
        end
        rd(4'h4, s);
        check(s[2] == 1'b1, "R10 rx empty after drain", s[2], 1);
    endtask

    task automatic t_manual();
        logic [31:0] s;
        int b0;
        cpol_tb = 0; cpha_tb = 0;
        wr(4'h8, 32'h3); ss_ok = 4'b1100;
        wr(4'h0, 32'h8);
        @(negedge clk);
        check(ss_n == 4'b1100, "R6 manual idle", ss_n, 4'b1100);
        b0 = bad_ss;
        wr(4'hC, 32'hC6);
        wr(4'h0, 32'h9);
        wait_idle();
        check(bad_ss == b0, "R6 manual steady in burst", bad_ss - b0, 0);
        check(ss_n == 4'b1100, "R6 manual after burst", ss_n, 4'b1100);
        rd(4'hC, s);
        check(s[7:0] == 8'h39, "R2 manual rx", s[7:0], 8'h39);
        wr(4'h8, 32'h0);
        @(negedge clk);
        check(ss_n == 4'hF, "R6 manual deselect", ss_n, 4'hF);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_burst(1'b0, 1'b0, 1);
        t_burst(1'b1, 1'b0, 2);
        t_burst(1'b0, 1'b1, 3);
        t_burst(1'b1, 1'b1, 4);
        t_fill();
        t_manual();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule